// File: doc/BRIEF.md
# Edge-Sensing GPIO Controller

A 28-line general purpose I/O controller that sits behind a simple 32-bit register bus. Software chooses the direction of each line, drives the output latches through separate write-only set and clear registers, and reads the synchronised level of every pin. An alternate-function register passes chosen pins to other on-chip peripherals. That register is only brought out as a select vector; the muxing lives outside this block.

Each input goes through a two-flop synchroniser. A rising-edge enable and a falling-edge enable decide, line by line, which transitions set a sticky status bit. Software clears status bits by writing 1 to them. Lines 0 to 10 each raise their own interrupt output. The status bits of lines 11 to 27 are ORed into one shared interrupt.

Register words are addressed by byte offset:
- 0x00: level, read only.
- 0x04: direction.
- 0x08: set, write only.
- 0x0C: clear, write only.
- 0x10: rising-edge enable.
- 0x14: falling-edge enable.
- 0x18: edge status.
- 0x1C: alternate function.

Reads are combinational from the address. Writes take effect at the clock edge on which `bus_wr` is sampled high.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_out`, `pin_oe`, `alt_sel`, `irq_line` and `irq_shared` are all 0.
- R2: The direction register (0x04) reads back what was written, and a 1 in bit i drives `pin_oe[i]` high, marking line i as an output.
- R3: Writing a mask to 0x08 sets the selected output latches to 1. Writing a mask to 0x0C clears them to 0. Zero bits leave latches unchanged, and both registers read as 0.
- R4: The level register (0x00) shows `pin_in` two clock edges after it changes, not one, whatever the direction of the line.
- R5: A rising edge on a line with its rising enable (0x10) set, or a falling edge with its falling enable (0x14) set, sets that line's status bit on the third clock edge after the pin changes. A line with both enables set detects either edge. A line with neither set never sets its status bit.
- R6: Writing 1 to a bit of the status register (0x18) clears it. Writing 0 leaves it, so an all-zero write has no effect.
- R7: When an enabled edge and a clear write hit the same status bit in the same cycle, the bit ends set.
- R8: `irq_line[i]` equals status bit i for lines 0 to 10.
- R9: `irq_shared` is high exactly when any status bit from 11 to 27 is set.
- R10: The alternate-function register (0x1C) reads back what was written and drives `alt_sel`, where 1 hands the pin to its alternate function.
- R11: Bits 31 to 28 of every register read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 28 | Pad input levels |
| pin_out | output | 28 | Output latches |
| pin_oe | output | 28 | Output enables (direction) |
| alt_sel | output | 28 | Alternate-function select |
| irq_line | output | 11 | Dedicated interrupts for lines 0 to 10 |
| irq_shared | output | 1 | OR of the status of lines 11 to 27 |

## Verification
Register writes are visible at the falling edge right after the rising edge that samples the strobe. The level register updates two rising edges after a pin change, and the status bits and interrupts update three rising edges after it. The bench drives inputs and samples outputs on falling edges, so it counts those edges exactly. Level is checked one edge early, when it must still hold the old value, and status two edges after the change, when it must still be clear. The same-cycle priority test places the clear write in the one cycle where the edge is being detected.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    typedef enum logic [2:0] {
        SEL_LEVEL = 3'd0,
        SEL_DIR   = 3'd1,
        SEL_SET   = 3'd2,
        SEL_CLR   = 3'd3,
        SEL_RISE  = 3'd4,
        SEL_FALL  = 3'd5,
        SEL_STAT  = 3'd6,
        SEL_ALT   = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 28,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign chain_d[s] = async_i;
            end else begin : g_next
                assign chain_d[s] = chain_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_d[s];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] rise_en_i,
    input  logic [WIDTH-1:0] fall_en_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] status_o
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] status;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [WIDTH-1:0] hit;

    always_comb begin
        st_d        = st_q;
        hit         = (sync_i & ~st_q.prev & rise_en_i) |
                      (~sync_i & st_q.prev & fall_en_i);
        st_d.prev   = sync_i;
        st_d.status = (st_q.status & ~clr_i) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;

    // R7: a detected edge survives a clear in the same cycle
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((status_o & $past(hit)) == $past(hit)));

    // R6: bits written with 1 and not hit are cleared
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((status_o & $past(clr_i & ~hit)) == '0));

    // R6: with no clear and no edge the status holds
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0 && hit == '0) |=> $stable(status_o));

    // R5: a newly set bit always had an enabled edge behind it
    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) &
                   ~$past((sync_i & ~st_q.prev & rise_en_i) |
                          (~sync_i & st_q.prev & fall_en_i))) == '0));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_edge_pkg::*;
#(
    parameter int N      = 28,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [N-1:0]      level_i,
    input  logic [N-1:0]      status_i,
    output logic [N-1:0]      dir_o,
    output logic [N-1:0]      out_o,
    output logic [N-1:0]      rise_en_o,
    output logic [N-1:0]      fall_en_o,
    output logic [N-1:0]      alt_o,
    output logic [N-1:0]      clr_o
);
    typedef struct packed {
        logic [N-1:0] dir;
        logic [N-1:0] outv;
        logic [N-1:0] rise;
        logic [N-1:0] fall;
        logic [N-1:0] alt;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    reg_sel_e   sel;
    logic [N-1:0] wd;
    logic [N-1:0] rd;
    logic unused_bits;

    assign sel = reg_sel_e'(addr_i[ADDR_W-1:2]);
    assign wd  = wdata_i[N-1:0];
    assign unused_bits = ^{wdata_i[DATA_W-1:N], addr_i[1:0]};

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        if (wr_i) begin
            case (sel)
                SEL_DIR:  st_d.dir  = wd;
                SEL_SET:  st_d.outv = st_q.outv | wd;
                SEL_CLR:  st_d.outv = st_q.outv & ~wd;
                SEL_RISE: st_d.rise = wd;
                SEL_FALL: st_d.fall = wd;
                SEL_STAT: clr_o     = wd;
                SEL_ALT:  st_d.alt  = wd;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (sel)
            SEL_LEVEL: rd = level_i;
            SEL_DIR:   rd = st_q.dir;
            SEL_RISE:  rd = st_q.rise;
            SEL_FALL:  rd = st_q.fall;
            SEL_STAT:  rd = status_i;
            SEL_ALT:   rd = st_q.alt;
            default:   rd = '0;
        endcase
    end

    assign rdata_o   = {{(DATA_W-N){1'b0}}, rd};
    assign dir_o     = st_q.dir;
    assign out_o     = st_q.outv;
    assign rise_en_o = st_q.rise;
    assign fall_en_o = st_q.fall;
    assign alt_o     = st_q.alt;

    // R3: set mask drives selected latches high
    p_set_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == SEL_SET) |=> ((out_o & $past(wd)) == $past(wd)));

    // R3: clear mask drives selected latches low, others keep value
    p_clr_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == SEL_CLR) |=>
            (out_o == ($past(out_o) & ~$past(wd))));

    // R2: direction only changes through its own write
    p_dir_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel == SEL_DIR) |=> $stable(dir_o));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
    parameter int N         = 28,
    parameter int N_DEDIC   = 11,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 5,
    parameter int SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N-1:0]      pin_in,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_oe,
    output logic [N-1:0]      alt_sel,
    output logic [N_DEDIC-1:0] irq_line,
    output logic              irq_shared
);
    localparam int N_SHARED = N - N_DEDIC;

    logic [N-1:0] level, status, rise_en, fall_en, clr;

    gpio_sync #(.WIDTH(N), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(level)
    );

    gpio_edge_det #(.WIDTH(N)) u_det (
        .clk(clk), .rst_n(rst_n), .sync_i(level),
        .rise_en_i(rise_en), .fall_en_i(fall_en),
        .clr_i(clr), .status_o(status)
    );

    gpio_regfile #(.N(N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .level_i(level), .status_i(status),
        .dir_o(pin_oe), .out_o(pin_out), .rise_en_o(rise_en),
        .fall_en_o(fall_en), .alt_o(alt_sel), .clr_o(clr)
    );

    generate
        for (genvar i = 0; i < N_DEDIC; i++) begin : g_dedic
            assign irq_line[i] = status[i];
        end
    endgenerate

    assign irq_shared = |status[N-1 -: N_SHARED];

    // R9: shared interrupt cannot rise without an upper-line edge enabled
    p_shared_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_shared) |-> ($past(rise_en[N-1 -: N_SHARED] |
                                     fall_en[N-1 -: N_SHARED]) != '0));
endmodule

// File: tb/gpio_edge_ctrl_tb_top.sv
module gpio_edge_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [27:0] pin_in = '0;
    logic [27:0] pin_out, pin_oe, alt_sel;
    logic [10:0] irq_line;
    logic        irq_shared;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel),
        .irq_line(irq_line), .irq_shared(irq_shared)
    );

    localparam logic [4:0] A_LVL = 5'h00, A_DIR = 5'h04, A_SET = 5'h08,
                           A_CLR = 5'h0C, A_RIS = 5'h10, A_FAL = 5'h14,
                           A_STA = 5'h18, A_ALT = 5'h1C;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), v);
            check("R1 reg reset", v, 32'h0);
        end
        check("R1 outputs reset", {pin_out, irq_line, irq_shared}, 32'h0);
        check("R1 oe/alt reset", {4'h0, pin_oe | alt_sel}, 32'h0);
    endtask

    task automatic t_dir;
        logic [31:0] v;
        wr(A_DIR, 32'h0123_4567);
        rd(A_DIR, v);
        check("R2 dir readback", v, 32'h0123_4567);
        check("R2 pin_oe", {4'h0, pin_oe}, 32'h0123_4567);
    endtask

    task automatic t_set_clr;
        logic [31:0] v;
        wr(A_SET, 32'h00F0_F00F);
        check("R3 set", {4'h0, pin_out}, 32'h00F0_F00F);
        wr(A_SET, 32'h0000_0100);
        check("R3 set keeps others", {4'h0, pin_out}, 32'h00F0_F10F);
        wr(A_CLR, 32'h0000_F003);
        check("R3 clear", {4'h0, pin_out}, 32'h00F0_010C);
        rd(A_SET, v);
        check("R3 set reads zero", v, 32'h0);
        rd(A_CLR, v);
        check("R3 clear reads zero", v, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        pin_in = 28'hA5A_5A5A;
        @(negedge clk);
        rd(A_LVL, v);
        check("R4 level one edge late", v, 32'h0);
        @(negedge clk);
        rd(A_LVL, v);
        check("R4 level after two edges", v, 32'h0A5A_5A5A);
        pin_in = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_edges;
        logic [31:0] v;
        wr(A_STA, 32'hFFFF_FFFF);
        wr(A_RIS, 32'h0000_0028);   // lines 3 and 5
        wr(A_FAL, 32'h0000_1020);   // lines 5 and 12
        pin_in = 28'h000_10A8;      // lines 3,5,7,12 rise
        repeat (2) @(negedge clk);
        rd(A_STA, v);
        check("R5 status not yet set", v, 32'h0);
        @(negedge clk);
        rd(A_STA, v);
        check("R5 rising edges", v, 32'h0000_0028);
        check("R8 dedicated irq", {21'h0, irq_line}, 32'h0000_0028);
        check("R9 shared idle", {31'h0, irq_shared}, 32'h0);
        pin_in = '0;
        repeat (3) @(negedge clk);
        rd(A_STA, v);
        check("R5 falling edges", v, 32'h0000_1028);
        check("R9 shared raised", {31'h0, irq_shared}, 32'h1);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(A_STA, 32'h0);
        rd(A_STA, v);
        check("R6 zero write no effect", v, 32'h0000_1028);
        wr(A_STA, 32'h0000_1000);
        rd(A_STA, v);
        check("R6 clear one bit", v, 32'h0000_0028);
        check("R9 shared cleared", {31'h0, irq_shared}, 32'h0);
        wr(A_STA, 32'hFFFF_FFFF);
        rd(A_STA, v);
        check("R6 clear all", v, 32'h0);
        check("R8 irq cleared", {21'h0, irq_line}, 32'h0);
    endtask

    task automatic t_priority;
        logic [31:0] v;
        pin_in = 28'h000_0020;
        repeat (2) @(negedge clk);
        wr(A_STA, 32'h0000_0020);   // lands on the detect cycle
        rd(A_STA, v);
        check("R7 set beats clear", v, 32'h0000_0020);
        wr(A_STA, 32'h0000_0020);
        rd(A_STA, v);
        check("R7 later clear works", v, 32'h0);
        pin_in = '0;
        repeat (3) @(negedge clk);
        wr(A_STA, 32'hFFFF_FFFF);
    endtask

    task automatic t_alt;
        logic [31:0] v;
        wr(A_ALT, 32'h0800_0001);
        rd(A_ALT, v);
        check("R10 alt readback", v, 32'h0800_0001);
        check("R10 alt_sel", {4'h0, alt_sel}, 32'h0800_0001);
    endtask

    task automatic t_upper;
        logic [31:0] v;
        wr(A_DIR, 32'hFFFF_FFFF);
        rd(A_DIR, v);
        check("R11 upper bits zero", v, 32'h0FFF_FFFF);
        wr(A_RIS, 32'hF000_0000);
        rd(A_RIS, v);
        check("R11 upper-only write ignored", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir();
        t_set_clr();
        t_level();
        t_edges();
        t_w1c();
        t_priority();
        t_alt();
        t_upper();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule